// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block picks one of two unrelated source clocks and drives it onto a single output clock without ever producing a shortened high or low phase. A third, free-running control clock runs a small sequencer. When the requested source changes, the sequencer turns both source gates off and waits until each one is confirmed off. Only then does it move the final 2:1 mux, and after that it turns on the gate of the new source. A per-source activity monitor lets the sequence finish even when one or both sources have stopped toggling.

The sequencer has five states. ST_RUN is steady operation. ST_DRAIN turns both gates off and waits for the off-confirmation. ST_SWAP is the one-cycle quiet window in which the mux moves. ST_FILL turns on the new gate and waits for its on-confirmation. ST_HALT holds both gates off while a stop request is held.

The transitions are as follows:
- ST_RUN goes to ST_DRAIN when the stop request is seen, or when the requested source differs from the current one.
- ST_DRAIN goes to ST_HALT if the sequence was started by a stop request. Otherwise it goes to ST_SWAP.
- ST_SWAP always goes to ST_FILL.
- ST_FILL goes to ST_RUN once the new gate is confirmed on.
- ST_HALT goes to ST_SWAP when the stop request is released.

The select, test and stop inputs pass through synchronizers into the control domain. Gate enables cross into each source domain through synchronizers, and each gate's latched state is synchronized back.

Top module: `gf_clk_switch`

## Requirements
- R1: With `test_en` low and the block idle, `pick_b` = 0 puts `clk_a` on `clk_out`, and `pick_b` = 1 puts `clk_b` on `clk_out`.
- R2: At no time are both gate enables active, and both are inactive before the mux select moves.
- R3: The mux select changes only when each source gate is confirmed off, or its source is reported as not toggling.
- R4: `busy` rises within six control cycles of a select change and stays high until the new source is confirmed on; then it falls.
- R5: A select change made while a sequence runs does not alter that sequence's target. It is acted on only after `busy` falls, which starts a new sequence.
- R6: Asserting `halt_req` raises `busy` until both gates are confirmed off; `clk_out` then shows no edges and `busy` stays low. Select changes during the halt cause no activity. Releasing it raises `busy` until the requested source is running again.
- R7: `test_en` high selects `clk_a` regardless of `pick_b`.
- R8: A switch to or from a source that is not toggling completes, and `busy` falls.
- R9: `clk_out` never has a high or low phase shorter than the shortest half period of the running sources.
- R10: During and after reset `busy` is low, and `clk_a` is the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Source clock chosen when select is 0 |
| clk_b | input | 1 | Source clock chosen when select is 1 |
| ctrl_clk | input | 1 | Free-running clock for the sequencer and activity monitors |
| rst_n | input | 1 | Asynchronous active-low reset for all three domains |
| pick_b | input | 1 | Requested source: 0 selects clk_a, 1 selects clk_b |
| test_en | input | 1 | Forces clk_a onto the output |
| halt_req | input | 1 | Gates both sources off while held |
| clk_out | output | 1 | Switched output clock |
| busy | output | 1 | High while a switch, stop or resume sequence runs |

## Verification
The bound checker checks, on every control cycle, the ordering rules. At most one gate enable is active. The mux moves only after both gates are confirmed off or reported idle. The in-flight target holds while `busy` is high. A stop request seen in ST_RUN raises `busy`. Test mode keeps the mux on `clk_a` while idle. Only the bench scenarios can show which source actually reaches `clk_out`, measured by counting edges. They also show that switches complete when sources are stopped, that halting silences the output, and the shortest pulse on the output, which is the glitch-freedom the sequencing exists for.

// File: rtl/gfcs_pkg.sv
package gfcs_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_DRAIN = 3'd1,
        ST_SWAP  = 3'd2,
        ST_FILL  = 3'd3,
        ST_HALT  = 3'd4
    } gfcs_state_e;
endpackage

// File: rtl/gfcs_sync.sv
module gfcs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/gfcs_activity.sv
// Handshake-based activity monitor: the source toggles a request only after
// the previous one was acknowledged, so no frequency ratio can alias it away.
module gfcs_activity #(
    parameter int TMO_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic ctrl_clk,
    input  logic rst_n,
    output logic alive
);
    localparam logic [TMO_W-1:0] TMO_MAX = '1;

    logic req_s, ack_s, req_c, ack_c;
    logic [TMO_W-1:0] idle_cnt;

    gfcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
        .clk(src_clk), .rst_n(rst_n), .d(ack_c), .q(ack_s)
    );

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n)            req_s <= 1'b0;
        else if (ack_s == req_s) req_s <= ~req_s;
    end

    gfcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk(ctrl_clk), .rst_n(rst_n), .d(req_s), .q(req_c)
    );

    always_ff @(posedge ctrl_clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_c    <= 1'b0;
            idle_cnt <= '0;
            alive    <= 1'b0;
        end else if (req_c != ack_c) begin
            ack_c    <= req_c;
            idle_cnt <= '0;
            alive    <= 1'b1;
        end else if (idle_cnt == TMO_MAX) begin
            alive    <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gfcs_gate.sv
// Clock gate: enable synchronized into the source domain, held by a latch
// that is open only while the source is low, state reported back to control.
module gfcs_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic ctrl_clk,
    input  logic rst_n,
    input  logic en_req,
    output logic gclk,
    output logic on_c
);
    logic en_s;
    logic en_lat;

    gfcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk(src_clk), .rst_n(rst_n), .d(en_req), .q(en_s)
    );

    always_latch begin
        if (!src_clk) en_lat = en_s;
    end

    assign gclk = src_clk & en_lat;

    gfcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_state_sync (
        .clk(ctrl_clk), .rst_n(rst_n), .d(en_lat), .q(on_c)
    );
endmodule

// File: rtl/gfcs_fsm.sv
module gfcs_fsm
    import gfcs_pkg::*;
(
    input  logic        ctrl_clk,
    input  logic        rst_n,
    input  logic        sel_c,
    input  logic        test_c,
    input  logic        halt_c,
    input  logic        on_a,
    input  logic        on_b,
    input  logic        alive_a,
    input  logic        alive_b,
    output logic        en_a,
    output logic        en_b,
    output logic        mux_sel,
    output logic        busy,
    output gfcs_state_e state,
    output logic        tgt
);
    gfcs_state_e nxt;
    logic halting;
    logic want, off_a, off_b, new_on;

    assign want   = test_c ? 1'b0 : sel_c;
    assign off_a  = !on_a || !alive_a;
    assign off_b  = !on_b || !alive_b;
    assign new_on = mux_sel ? (on_b || !alive_b) : (on_a || !alive_a);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (halt_c || (want != mux_sel)) nxt = ST_DRAIN;
            ST_DRAIN: if (off_a && off_b) nxt = halting ? ST_HALT : ST_SWAP;
            ST_SWAP:  nxt = ST_FILL;
            ST_FILL:  if (new_on) nxt = ST_RUN;
            ST_HALT:  if (!halt_c) nxt = ST_SWAP;
            default:  nxt = ST_RUN;
        endcase
    end

    // state register with the target, mux and halt bookkeeping it carries
    always_ff @(posedge ctrl_clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            tgt     <= 1'b0;
            mux_sel <= 1'b0;
            halting <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && nxt == ST_DRAIN) begin
                tgt     <= want;
                halting <= halt_c;
            end
            if (state == ST_HALT && nxt == ST_SWAP) begin
                tgt     <= want;
                halting <= 1'b0;
            end
            if (state == ST_SWAP) mux_sel <= tgt;
        end
    end

    // outputs
    always_comb begin
        en_a = 1'b0;
        en_b = 1'b0;
        busy = 1'b0;
        unique case (state)
            ST_RUN: begin
                en_a = !mux_sel;
                en_b = mux_sel;
            end
            ST_DRAIN, ST_SWAP: busy = 1'b1;
            ST_FILL: begin
                en_a = !mux_sel;
                en_b = mux_sel;
                busy = 1'b1;
            end
            ST_HALT: busy = 1'b0;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/gf_clk_switch.sv
module gf_clk_switch
    import gfcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 6
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic ctrl_clk,
    input  logic rst_n,
    input  logic pick_b,
    input  logic test_en,
    input  logic halt_req,
    output logic clk_out,
    output logic busy
);
    localparam int N_CTL = 3;

    logic [N_CTL-1:0] ctl_raw, ctl_sync;
    logic en_a, en_b, on_a, on_b, alive_a, alive_b;
    logic gclk_a, gclk_b, mux_sel, fsm_tgt;
    gfcs_state_e fsm_state;

    assign ctl_raw = {halt_req, test_en, pick_b};

    for (genvar i = 0; i < N_CTL; i++) begin : g_ctl_sync
        gfcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk(ctrl_clk), .rst_n(rst_n), .d(ctl_raw[i]), .q(ctl_sync[i])
        );
    end

    gfcs_activity #(.TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)) u_act_a (
        .src_clk(clk_a), .ctrl_clk(ctrl_clk), .rst_n(rst_n), .alive(alive_a)
    );
    gfcs_activity #(.TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)) u_act_b (
        .src_clk(clk_b), .ctrl_clk(ctrl_clk), .rst_n(rst_n), .alive(alive_b)
    );

    gfcs_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_a (
        .src_clk(clk_a), .ctrl_clk(ctrl_clk), .rst_n(rst_n),
        .en_req(en_a), .gclk(gclk_a), .on_c(on_a)
    );
    gfcs_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_b (
        .src_clk(clk_b), .ctrl_clk(ctrl_clk), .rst_n(rst_n),
        .en_req(en_b), .gclk(gclk_b), .on_c(on_b)
    );

    gfcs_fsm u_fsm (
        .ctrl_clk(ctrl_clk), .rst_n(rst_n),
        .sel_c(ctl_sync[0]), .test_c(ctl_sync[1]), .halt_c(ctl_sync[2]),
        .on_a(on_a), .on_b(on_b), .alive_a(alive_a), .alive_b(alive_b),
        .en_a(en_a), .en_b(en_b), .mux_sel(mux_sel), .busy(busy),
        .state(fsm_state), .tgt(fsm_tgt)
    );

    assign clk_out = mux_sel ? gclk_b : gclk_a;
endmodule

// File: rtl/gfcs_chk.sv
module gfcs_chk
    import gfcs_pkg::*;
(
    input logic        ctrl_clk,
    input logic        rst_n,
    input gfcs_state_e state,
    input logic        tgt,
    input logic        mux_sel,
    input logic        en_a,
    input logic        en_b,
    input logic        on_a,
    input logic        on_b,
    input logic        alive_a,
    input logic        alive_b,
    input logic        busy,
    input logic        halt_c,
    input logic        test_c
);
    p_one_gate_r2: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
        $countones({en_a, en_b}) <= 1);

    p_mux_quiet_r3: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
        (mux_sel != $past(mux_sel)) |->
            ($past(!en_a && !en_b) &&
             $past((!on_a || !alive_a) && (!on_b || !alive_b))));

    p_hold_tgt_r5: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tgt));

    p_halt_busy_r6: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
        (halt_c && state == ST_RUN) |=> busy);

    p_test_sel_r7: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state == ST_RUN) && $past(test_c)) |-> !mux_sel);
endmodule

bind gf_clk_switch gfcs_chk u_chk (
    .ctrl_clk(ctrl_clk), .rst_n(rst_n), .state(fsm_state), .tgt(fsm_tgt),
    .mux_sel(mux_sel), .en_a(en_a), .en_b(en_b), .on_a(on_a), .on_b(on_b),
    .alive_a(alive_a), .alive_b(alive_b), .busy(busy),
    .halt_c(ctl_sync[2]), .test_c(ctl_sync[1])
);

// File: tb/gf_clk_switch_tb_top.sv
`timescale 1ns/1ps
module gf_clk_switch_tb_top;
    logic clk_a = 1'b0, clk_b = 1'b0, ctrl_clk = 1'b0;
    logic rst_n = 1'b0, pick_b = 1'b0, test_en = 1'b0, halt_req = 1'b0;
    logic clk_out, busy;
    logic run_a = 1'b1, run_b = 1'b1;

    int n_chk = 0, n_err = 0;
    int edge_cnt = 0;
    real t_last = 0.0, min_w = 1.0e9;

    gf_clk_switch dut_i (
        .clk_a(clk_a), .clk_b(clk_b), .ctrl_clk(ctrl_clk), .rst_n(rst_n),
        .pick_b(pick_b), .test_en(test_en), .halt_req(halt_req),
        .clk_out(clk_out), .busy(busy)
    );

    always #10 ctrl_clk = ~ctrl_clk;               // 50 MHz control clock
    always begin #15; if (run_a) clk_a = ~clk_a; else clk_a = 1'b0; end
    always begin #35; if (run_b) clk_b = ~clk_b; else clk_b = 1'b0; end

    always @(posedge clk_out) edge_cnt++;
    always @(clk_out) begin
        if (t_last > 0.0 && ($realtime - t_last) < min_w) min_w = $realtime - t_last;
        t_last = $realtime;
    end

    // 0 = no clock, 1 = clk_a, 2 = clk_b, 3 = unclear
    function automatic int classify(int n);
        if (n == 0) return 0;
        if (n >= 55 && n <= 80) return 1;
        if (n >= 20 && n <= 40) return 2;
        return 3;
    endfunction

    function automatic int exp_src(logic s, logic t);
        return t ? 1 : (s ? 2 : 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(output int code);
        int c0;
        c0 = edge_cnt;
        #2100;
        code = classify(edge_cnt - c0);
    endtask

    task automatic wait_idle();
        repeat (6) @(negedge ctrl_clk);
        for (int i = 0; i < 3000 && busy; i++) @(negedge ctrl_clk);
        repeat (4) @(negedge ctrl_clk);
    endtask

    initial begin
        #3_000_000;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int code;
        bit s, t, saw_low, again;
        void'($urandom(32'h5eed_c10c));

        repeat (5) @(negedge ctrl_clk);
        check(busy == 1'b0, "R10 busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge ctrl_clk);
        check(busy == 1'b0, "R10 busy after reset", busy, 0);
        measure(code);
        check(code == 1, "R10 clk_a after reset", code, 1);

        pick_b = 1'b1;
        repeat (6) @(negedge ctrl_clk);
        check(busy == 1'b1, "R4 busy raised", busy, 1);
        wait_idle();
        check(busy == 1'b0, "R4 busy dropped", busy, 0);
        measure(code);
        check(code == 2, "R1 clk_b selected", code, 2);

        // R5: bounce select back during the sequence
        pick_b = 1'b0;
        repeat (6) @(negedge ctrl_clk);
        pick_b = 1'b1;
        saw_low = 1'b0; again = 1'b0;
        for (int i = 0; i < 3000 && !saw_low; i++) begin
            @(negedge ctrl_clk);
            if (!busy) saw_low = 1'b1;
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge ctrl_clk);
            if (busy) again = 1'b1;
        end
        check(saw_low && again, "R5 deferred change restarts", int'(again), 1);
        wait_idle();
        measure(code);
        check(code == 2, "R5 final source", code, 2);

        test_en = 1'b1;
        wait_idle();
        measure(code);
        check(code == 1, "R7 test forces clk_a", code, 1);
        test_en = 1'b0;
        wait_idle();
        measure(code);
        check(code == 2, "R1 back to clk_b", code, 2);

        halt_req = 1'b1;
        repeat (6) @(negedge ctrl_clk);
        check(busy == 1'b1, "R6 busy on halt", busy, 1);
        wait_idle();
        check(busy == 1'b0, "R6 busy after halt", busy, 0);
        measure(code);
        check(code == 0, "R6 output quiet", code, 0);
        pick_b = 1'b0;
        repeat (10) @(negedge ctrl_clk);
        check(busy == 1'b0, "R6 select ignored busy", busy, 0);
        measure(code);
        check(code == 0, "R6 select ignored output", code, 0);
        halt_req = 1'b0;
        repeat (6) @(negedge ctrl_clk);
        check(busy == 1'b1, "R6 busy on resume", busy, 1);
        wait_idle();
        measure(code);
        check(code == 1, "R6 resumed on clk_a", code, 1);

        // R8: stopped sources
        @(negedge clk_b); run_b = 1'b0;
        repeat (200) @(negedge ctrl_clk);
        pick_b = 1'b1;
        wait_idle();
        check(busy == 1'b0, "R8 switch to stopped clk_b", busy, 0);
        measure(code);
        check(code == 0, "R8 stopped output", code, 0);
        pick_b = 1'b0;
        wait_idle();
        measure(code);
        check(code == 1, "R8 switch away from stopped", code, 1);
        @(negedge clk_a); run_a = 1'b0;
        repeat (200) @(negedge ctrl_clk);
        pick_b = 1'b1;
        wait_idle();
        check(busy == 1'b0, "R8 both stopped", busy, 0);
        run_a = 1'b1; run_b = 1'b1;
        repeat (200) @(negedge ctrl_clk);
        measure(code);
        check(code == 2, "R8 restart on clk_b", code, 2);

        for (int k = 0; k < 12; k++) begin
            s = 1'($urandom % 2);
            t = ($urandom % 4) == 0;
            pick_b = s; test_en = t;
            wait_idle();
            measure(code);
            check(code == exp_src(s, t), "R1 R7 random select", code, exp_src(s, t));
        end

        // R9 (with R2 R3 ordering): no runt phase on the output
        check(min_w >= 14.9, "R2 R3 R9 min pulse ps", int'(min_w * 1000.0), 15000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule